// File: doc/BRIEF.md
# Address-Keyed Serial Clock Register Interface

This block sits beside a read-only memory and watches the low address lines on every bus access. It is meant for a clock register file that shares the memory's address space and has no pins of its own. Software talks to it only through ordinary memory accesses. Address bit 0 carries a data bit, and address bit 2 separates writes (low) from reads (high). A 64-bit key presented one bit per access unlocks the block. After that, exactly one whole 64-bit register file moves serially in either direction.

While the block is locked, every read returns the memory byte unchanged. After an unlock, the first access decides the direction of the transfer. In a read transfer, each read returns one register bit on data bit 0. In a write transfer, each write access supplies one bit on address bit 0. The register file holds eight BCD bytes in a fixed order: hundredths, seconds, minutes, hours, weekday, date, month, year. A 64-bit holding register stands in for the running clock, and it is visible on a port.

Top module: `phantom_rtc`

## Requirements
- R1: While locked, data_o equals mem_data_i on every cycle.
- R2: Only cycles with acc_i high count as accesses. An access with addr_i[2]=0 is a write of the bit addr_i[0]. An access with addr_i[2]=1 is a read.
- R3: A read access while locked sets the key comparison pointer back to the first key bit. A key that follows a read therefore unlocks, whatever partial key came before it.
- R4: The key is the bytes C5,3A,A3,5C,C5,3A,A3,5C, sent in that order, each byte LSB first, as 64 write accesses. A write bit that differs from the expected key bit clears the pointer, and the block stays locked.
- R5: In a read transfer, the n-th read (n=0..63) returns bit n of regs_o on data_o[0]; data_o[7:1] equals mem_data_i[7:1]. Bit n of regs_o is bit n%8 of byte n/8, and byte 0 (hundredths) is regs_o[7:0].
- R6: In a write transfer, the n-th write supplies bit n of the new register file, in the same order as R5. regs_o stays unchanged until the 64th bit, then takes all 64 bits in the same cycle.
- R7: After the 64th bit of either transfer, the block is locked again, and the next read passes memory through.
- R8: The first access after an unlock selects the direction. An access of the other kind ends the transfer: the block relocks, regs_o is unchanged, and the aborting access passes memory data through.
- R9: rst_ni low puts the block in the locked state with the pointer at zero and regs_o equal to RESET_VALUE (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 1 | One-cycle bus access strobe |
| addr_i | input | ADDR_W | Low address bits: bit 0 data in, bit 2 write-not |
| mem_data_i | input | DATA_W | Byte read from the memory |
| data_o | output | DATA_W | Byte returned to the bus |
| regs_o | output | 8*NBYTES | Holding register file |

## Verification
The bench sends the key with one bit flipped at positions across all 64. A comparator that ignored mismatches, or kept a stale pointer, would unlock and drive clock bits onto D0. Several register values make round trips through write and read, which exposes a reversed bit order or byte order. The bench samples regs_o just before the final write bit, so a design that commits bits one at a time shows a torn value. Transfers are cut off by an access of the other direction; a design that failed to relock would corrupt the holding register or keep driving D0. Partial keys followed by a read, and idle cycles with junk addresses, check that the pointer resets on a read and that non-strobed cycles are ignored.

// File: rtl/phantom_rtc_pkg.sv
package phantom_rtc_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_ARMED  = 2'd1,
    ST_READ   = 2'd2,
    ST_WRITE  = 2'd3
  } xfer_state_e;

  localparam int unsigned ADDR_DIN_BIT = 0;
  localparam int unsigned ADDR_WRN_BIT = 2;
endpackage

// File: rtl/phrtc_key_match.sv
module phrtc_key_match #(
  parameter int unsigned   KEY_W = 64,
  parameter logic [KEY_W-1:0] KEY = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic acc_i,
  input  logic wr_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int unsigned PTR_W = (KEY_W > 1) ? $clog2(KEY_W) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(KEY_W - 1);

  logic [PTR_W-1:0] ptr_q;
  logic             bit_ok;

  assign bit_ok = (bit_i == KEY[ptr_q]);
  assign hit_o  = en_i && acc_i && wr_i && bit_ok && (ptr_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ptr_q <= '0;
    else if (!en_i)                  ptr_q <= '0;
    else if (acc_i) begin
      if (!wr_i || !bit_ok)          ptr_q <= '0;
      else if (ptr_q == LAST)        ptr_q <= '0;
      else                           ptr_q <= ptr_q + PTR_W'(1);
    end
  end

  p_read_clears_ptr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && acc_i && !wr_i |=> ptr_q == '0);
  p_mismatch_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && acc_i && wr_i && (bit_i != KEY[ptr_q]) |=> ptr_q == '0);
  p_idle_holds_ptr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !acc_i && $past(en_i) |=> $stable(ptr_q));
endmodule

// File: rtl/phrtc_xfer_ctrl.sv
module phrtc_xfer_ctrl
  import phantom_rtc_pkg::*;
#(
  parameter int unsigned NBITS = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_i,
  input  logic                     wr_i,
  input  logic                     hit_i,
  output xfer_state_e              state_o,
  output logic [$clog2(NBITS)-1:0] idx_o,
  output logic                     rd_bit_o,
  output logic                     wr_bit_o,
  output logic                     commit_o
);
  localparam int unsigned CNT_W = $clog2(NBITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBITS - 1);

  xfer_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  assign state_o  = state_q;
  assign idx_o    = cnt_q;
  assign rd_bit_o = acc_i && !wr_i && (state_q == ST_ARMED || state_q == ST_READ);
  assign wr_bit_o = acc_i &&  wr_i && (state_q == ST_ARMED || state_q == ST_WRITE);
  assign commit_o = acc_i &&  wr_i && (state_q == ST_WRITE) && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOCKED;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_LOCKED: begin
          cnt_q <= '0;
          if (hit_i) state_q <= ST_ARMED;
        end
        ST_ARMED: if (acc_i) begin
          state_q <= wr_i ? ST_WRITE : ST_READ;
          cnt_q   <= CNT_W'(1);
        end
        ST_READ, ST_WRITE: if (acc_i) begin
          // opposite-direction access aborts; last bit relocks
          if (wr_i != (state_q == ST_WRITE) || cnt_q == LAST) begin
            state_q <= ST_LOCKED;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_LOCKED;
      endcase
    end
  end

  p_relock_after_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && (state_q == ST_READ || state_q == ST_WRITE) && cnt_q == LAST |=> state_q == ST_LOCKED);
  p_abort_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_READ && acc_i && wr_i |=> state_q == ST_LOCKED);
  p_abort_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WRITE && acc_i && !wr_i |=> state_q == ST_LOCKED);
  p_unlock_arms_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOCKED && hit_i |=> state_q == ST_ARMED);
endmodule

// File: rtl/phrtc_regfile.sv
module phrtc_regfile #(
  parameter int unsigned      NBITS       = 64,
  parameter logic [NBITS-1:0] RESET_VALUE = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_bit_i,
  input  logic                     commit_i,
  input  logic [$clog2(NBITS)-1:0] idx_i,
  input  logic                     din_i,
  output logic [NBITS-1:0]         regs_o,
  output logic                     rd_bit_o
);
  logic [NBITS-1:0] regs_q, shadow_q, shadow_d;

  always_comb begin
    shadow_d        = shadow_q;
    shadow_d[idx_i] = din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q   <= RESET_VALUE;
      shadow_q <= '0;
    end else begin
      if (wr_bit_i) shadow_q <= shadow_d;
      if (commit_i) regs_q   <= shadow_d;
    end
  end

  assign regs_o   = regs_q;
  assign rd_bit_o = regs_q[idx_i];

  p_regs_only_on_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(regs_q));
endmodule

// File: rtl/phantom_rtc.sv
module phantom_rtc
  import phantom_rtc_pkg::*;
#(
  parameter int unsigned             ADDR_W      = 3,
  parameter int unsigned             DATA_W      = 8,
  parameter int unsigned             NBYTES      = 8,
  parameter logic [8*NBYTES-1:0]     KEY         = 64'h5CA3_3AC5_5CA3_3AC5,
  parameter logic [8*NBYTES-1:0]     RESET_VALUE = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  acc_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     mem_data_i,
  output logic [DATA_W-1:0]     data_o,
  output logic [8*NBYTES-1:0]   regs_o
);
  localparam int unsigned NBITS = 8 * NBYTES;
  localparam int unsigned CNT_W = $clog2(NBITS);

  xfer_state_e      state;
  logic             is_wr, din, hit, rd_bit, wr_bit, commit, clk_bit;
  logic [CNT_W-1:0] idx;

  assign is_wr = !addr_i[ADDR_WRN_BIT];
  assign din   = addr_i[ADDR_DIN_BIT];

  phrtc_key_match #(.KEY_W(NBITS), .KEY(KEY)) u_match (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(state == ST_LOCKED),
    .acc_i (acc_i), .wr_i  (is_wr),  .bit_i(din), .hit_o(hit)
  );

  phrtc_xfer_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk_i   (clk_i),  .rst_ni  (rst_ni), .acc_i   (acc_i),
    .wr_i    (is_wr),  .hit_i   (hit),    .state_o (state),
    .idx_o   (idx),    .rd_bit_o(rd_bit), .wr_bit_o(wr_bit),
    .commit_o(commit)
  );

  phrtc_regfile #(.NBITS(NBITS), .RESET_VALUE(RESET_VALUE)) u_regs (
    .clk_i   (clk_i),  .rst_ni  (rst_ni), .wr_bit_i(wr_bit),
    .commit_i(commit), .idx_i   (idx),    .din_i   (din),
    .regs_o  (regs_o), .rd_bit_o(clk_bit)
  );

  always_comb begin
    data_o = mem_data_i;
    if (rd_bit) data_o[0] = clk_bit;
  end

  p_locked_passthru_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_LOCKED |-> data_o == mem_data_i);
  p_upper_bits_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_o[DATA_W-1:1] == mem_data_i[DATA_W-1:1]);
endmodule

// File: tb/phantom_rtc_tb_top.sv
module phantom_rtc_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acc_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  mem_data_i = '0;
  logic [7:0]  data_o;
  logic [63:0] regs_o;

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] key;
  logic [63:0] cur;

  always #4 clk_i = ~clk_i;

  phantom_rtc dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .addr_i(addr_i),
    .mem_data_i(mem_data_i), .data_o(data_o), .regs_o(regs_o)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic b, input logic [7:0] md, output logic [7:0] q);
    @(negedge clk_i);
    acc_i = 1'b1; addr_i = {~wr, 1'b1, b}; mem_data_i = md;
    #1 q = data_o;
    @(posedge clk_i);
    #1 acc_i = 1'b0;
  endtask

  task automatic idle_junk(input logic b);
    @(negedge clk_i);
    acc_i = 1'b0; addr_i = {1'b0, 1'b0, b};
  endtask

  task automatic rd_pass(input logic [7:0] md, input string req);
    logic [7:0] q;
    access(1'b0, 1'b0, md, q);
    chk(q == md, req, {56'd0, q}, {56'd0, md});
  endtask

  task automatic send_key(input int flip);
    logic [7:0] q;
    for (int i = 0; i < 64; i++) access(1'b1, key[i] ^ (i == flip), 8'h00, q);
  endtask

  task automatic write_val(input logic [63:0] v);
    logic [7:0] q;
    rd_pass(8'h3C, "R3");
    send_key(-1);
    for (int i = 0; i < 64; i++) begin
      if (i == 63) chk(regs_o == cur, "R6 no early update", regs_o, cur);
      access(1'b1, v[i], 8'h00, q);
    end
    cur = v;
    chk(regs_o == v, "R6 commit", regs_o, v);
  endtask

  task automatic read_val(output logic [63:0] v);
    logic [7:0] q, md;
    logic       up_ok;
    rd_pass(8'hA5, "R3");
    send_key(-1);
    up_ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      md = 8'((i * 37 + 5) & 255);
      access(1'b0, 1'b0, md, q);
      v[i] = q[0];
      if (q[7:1] != md[7:1]) up_ok = 1'b0;
    end
    chk(up_ok, "R5 upper bits", {63'd0, up_ok}, 64'd1);
  endtask

  initial begin
    logic [7:0]  bytes4 [4];
    logic [63:0] got, v;
    logic [7:0]  q;
    logic        all_ok;
    bytes4[0] = 8'hC5; bytes4[1] = 8'h3A; bytes4[2] = 8'hA3; bytes4[3] = 8'h5C;
    for (int i = 0; i < 8; i++) key[8*i +: 8] = bytes4[i % 4];
    cur = 64'd0;

    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    chk(regs_o == 64'd0, "R9 reset value", regs_o, 64'd0);
    for (int m = 0; m < 256; m += 17) rd_pass(8'(m), "R1 locked passthru");

    // round trips over several values
    for (int j = 0; j < 6; j++) begin
      v = (64'h0123_4567_89AB_CDEF * 64'(j + 1)) ^ {8{8'(j * 29)}};
      if (j == 0) v = 64'h9912_3104_2359_5999;
      write_val(v);
      rd_pass(8'h5A, "R7 relock after write");
      read_val(got);
      chk(got == v, "R5 read back", got, v);
      rd_pass(8'hC3, "R7 relock after read");
    end

    // flipped key bit at many positions: stays locked
    for (int k = 0; k < 64; k += 3) begin
      rd_pass(8'h00, "R3");
      send_key(k);
      all_ok = 1'b1;
      for (int i = 0; i < 64; i++) begin
        access(1'b0, 1'b0, 8'(i * 3 + 1), q);
        if (q != 8'(i * 3 + 1)) all_ok = 1'b0;
      end
      chk(all_ok, "R4 bad key stays locked", {63'd0, all_ok}, 64'd1);
    end
    chk(regs_o == cur, "R4 regs untouched", regs_o, cur);

    // partial key, then read resyncs; idle junk cycles ignored
    for (int i = 0; i < 20; i++) access(1'b1, key[i], 8'h00, q);
    rd_pass(8'h77, "R3 read resync");
    for (int i = 0; i < 64; i++) begin
      idle_junk(~key[i]);
      access(1'b1, key[i], 8'h00, q);
    end
    all_ok = 1'b1;
    for (int i = 0; i < 64; i++) begin
      access(1'b0, 1'b0, 8'hFE, q);
      got[i] = q[0];
    end
    chk(got == cur, "R2 R3 unlock after resync", got, cur);

    // write aborted by read
    rd_pass(8'h11, "R3");
    send_key(-1);
    for (int i = 0; i < 30; i++) access(1'b1, ~cur[i], 8'h00, q);
    access(1'b0, 1'b0, 8'h6E, q);
    chk(q == 8'h6E, "R8 abort read passthru", {56'd0, q}, 64'h6E);
    chk(regs_o == cur, "R8 write abort keeps regs", regs_o, cur);
    read_val(got);
    chk(got == cur, "R8 value after write abort", got, cur);

    // read aborted by write
    rd_pass(8'h22, "R3");
    send_key(-1);
    for (int i = 0; i < 10; i++) access(1'b0, 1'b0, 8'h00, q);
    access(1'b1, 1'b1, 8'h00, q);
    rd_pass(8'h01, "R8 relock after read abort");
    chk(regs_o == cur, "R8 read abort keeps regs", regs_o, cur);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule